// File: doc/BRIEF.md
# Super I/O Index/Data Configuration Port

This block gives a Super I/O controller its configuration window on a byte-wide ISA-style I/O bus. Two consecutive byte addresses, by default 0x3F0 and 0x3F1, make up the window. A byte written to the lower address picks a register index. The upper address then reads or writes the register that the index picks, in a file of 256 byte registers. The index is held in register 0 of that same file. Because of that, a read of index 0 through the data address returns zero, so the index does not show up a second time.

Writes through the data address are filtered by an irregular map of read-only indices. On reset the file clears and a fixed set of defaults is loaded in one cycle. These defaults are a device identifier, a function-select byte with every function off, and base-address codes for the floppy controller (0x3F0), the parallel port (0x378) and two serial ports (0x3F8 and 0x2F8). The index then reads back as 0.

A companion bridge owns the on/off control. One bit of one of its configuration bytes opens or closes the window. The block watches the bridge's configuration writes and copies that bit each time the byte is written. While the window is closed, reads return 0xFF and writes change nothing. The block does not decode the serial, parallel or floppy devices from the registers.

Top module: `sio_cfg_port`

## Requirements
- R1: A write to the base address (offset 0) stores the byte as the index. A read of offset 0 returns the current index.
- R2: A read of offset 1 returns the register that the index selects. When the index is 0x00, it returns 0x00.
- R3: A write to offset 1 stores the byte in the selected register when the index is 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC.
- R4: A write to offset 1 leaves the register file unchanged when the index is any other value: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF. This includes index 0, so a data-port write cannot alter the index.
- R5: After reset, every register reads 0x00 except these: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. The index reads 0x00.
- R6: The window is open only while the stored enable bit is 1. That bit is copied from bit 1 of the data of each bridge configuration write to byte 0x85. Writes to other bridge bytes leave it unchanged. It is 0 after reset.
- R7: While the window is closed, reads of either offset return 0xFF. Writes to either offset change neither the index nor any register.
- R8: Only the two addresses base and base+1 respond. A read of any other address returns 0xFF, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Single-byte write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe; io_rdata is valid in the same cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when not claimed |
| cfg_wr | input | 1 | Bridge configuration write strobe |
| cfg_addr | input | 8 | Bridge configuration byte offset |
| cfg_wdata | input | 8 | Bridge configuration write data |

## Verification
The bench goes after these corner cases:
- The edges of the read-only map: 0xE4 against 0xE3, 0xF5 against 0xF4 and 0xF6, 0xFC between 0xFB and 0xFD, and 0xDF. A design with an off-by-one range would store a write that must be dropped, or drop one that must be stored.
- Index 0 on the data address. A wrong design would either show the index again or let a data write overwrite the index.
- Writes while the window is closed, and writes to a neighbouring address. A leaky design would move the index or change a default.
- A bridge write with bit 1 set to the wrong configuration byte. A design with a loose decode would open the window.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE     = 16'h03F0,
  parameter logic [7:0]  EN_BYTE  = 8'h85,
  parameter int          EN_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata
);
  localparam int NREG = 256;

  logic [7:0] regs [NREG];
  logic       port_on;
  logic [7:0] index;
  logic       hit_idx, hit_dat;

  function automatic logic [7:0] reset_val(input logic [7:0] i);
    case (i)
      8'hE0:   reset_val = 8'h3C;
      8'hE2:   reset_val = 8'h03;
      8'hE3:   reset_val = 8'hFC;
      8'hE6:   reset_val = 8'hDE;
      8'hE7:   reset_val = 8'hFE;
      8'hE8:   reset_val = 8'hBE;
      default: reset_val = 8'h00;
    endcase
  endfunction

  function automatic logic writable(input logic [7:0] i);
    writable = (i >= 8'hE0) &&
               !(i inside {8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3, 8'hF5, 8'hF7,
                           [8'hF9:8'hFB], [8'hFD:8'hFF]});
  endfunction

  assign index   = regs[0];
  assign hit_idx = port_on && (io_addr == ADDR_W'(BASE));
  assign hit_dat = port_on && (io_addr == ADDR_W'(BASE + 16'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      port_on <= 1'b0;
    else if (cfg_wr && cfg_addr == EN_BYTE)
      port_on <= cfg_wdata[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reset_val(8'(i));
    end else if (io_wr && hit_idx) begin
      regs[0] <= io_wdata;
    end else if (io_wr && hit_dat && writable(index)) begin
      regs[index] <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && hit_idx)      io_rdata = index;
    else if (io_rd && hit_dat) io_rdata = (index == 8'h00) ? 8'h00 : regs[index];
  end

  assert_index_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && hit_idx) |=> $stable(index));
  assert_zero_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit_dat && index == 8'h00) |-> io_rdata == 8'h00);
  assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit_dat && writable(index)) |=> regs[$past(index)] == $past(io_wdata));
  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit_dat && !writable(index)) |=> regs[$past(index)] == $past(regs[index]));
  assert_enable_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == EN_BYTE) |=> port_on == $past(cfg_wdata[EN_BIT]));
  assert_closed_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_on && io_rd) |-> io_rdata == 8'hFF);
  assert_closed_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_on && io_wr) |=> $stable(index) && regs[$past(index)] == $past(regs[index]));
endmodule

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h0, cfg_wdata = 8'h0;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  localparam logic [15:0] IDX = 16'h03F0;
  localparam logic [15:0] DAT = 16'h03F1;

  always #10 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata));

  // {read, data_port, data, expected}; writes ignore expected
  localparam int NV = 32;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,1'b0,8'hE2,8'h00}, {1'b1,1'b0,8'h00,8'hE2},   // R1
    {1'b1,1'b1,8'h00,8'h03},                             // R2
    {1'b0,1'b1,8'hA5,8'h00}, {1'b1,1'b1,8'h00,8'hA5},   // R3 E2
    {1'b0,1'b0,8'hE4,8'h00}, {1'b0,1'b1,8'h55,8'h00}, {1'b1,1'b1,8'h00,8'h00}, // R4 E4
    {1'b0,1'b0,8'hE3,8'h00}, {1'b0,1'b1,8'h11,8'h00}, {1'b1,1'b1,8'h00,8'h11}, // R3 E3
    {1'b0,1'b0,8'h00,8'h00}, {1'b0,1'b1,8'h77,8'h00}, {1'b1,1'b0,8'h00,8'h00}, // R4 idx0
    {1'b1,1'b1,8'h00,8'h00},                             // R2 idx0
    {1'b0,1'b0,8'hFC,8'h00}, {1'b0,1'b1,8'h12,8'h00}, {1'b1,1'b1,8'h00,8'h12}, // R3 FC
    {1'b0,1'b0,8'hFD,8'h00}, {1'b0,1'b1,8'h34,8'h00}, {1'b1,1'b1,8'h00,8'h00}, // R4 FD
    {1'b0,1'b0,8'hF5,8'h00}, {1'b0,1'b1,8'h56,8'h00}, {1'b1,1'b1,8'h00,8'h00}, // R4 F5
    {1'b0,1'b0,8'hF4,8'h00}, {1'b0,1'b1,8'h9A,8'h00}, {1'b1,1'b1,8'h00,8'h9A}, // R3 F4
    {1'b0,1'b0,8'hDF,8'h00}, {1'b0,1'b1,8'hC3,8'h00}, {1'b1,1'b1,8'h00,8'h00}, // R4 DF
    {1'b0,1'b0,8'hE8,8'h00}, {1'b1,1'b1,8'h00,8'hBE}    // R5 survives
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #2 check(io_rdata, exp, req);
    io_rd = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic read_reg(input logic [7:0] i, input logic [7:0] exp, input string req);
    io_write(IDX, i);
    io_read(DAT, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R6: closed after reset
    io_read(IDX, 8'hFF, "R6 closed after reset");
    cfg_write(8'h84, 8'hFF);
    io_read(IDX, 8'hFF, "R6 other bridge byte");
    cfg_write(8'h85, 8'h02);
    io_read(IDX, 8'h00, "R5 index after reset");
    io_read(DAT, 8'h00, "R5 index0 read");
    read_reg(8'hE0, 8'h3C, "R5 E0");
    read_reg(8'hE1, 8'h00, "R5 E1");
    read_reg(8'hE2, 8'h03, "R5 E2");
    read_reg(8'hE3, 8'hFC, "R5 E3");
    read_reg(8'hE6, 8'hDE, "R5 E6");
    read_reg(8'hE7, 8'hFE, "R5 E7");
    read_reg(8'hE8, 8'hBE, "R5 E8");
    read_reg(8'hF0, 8'h00, "R5 F0");

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][17]) io_read(VEC[k][16] ? DAT : IDX, VEC[k][7:0], $sformatf("R1-R5 vector %0d", k));
      else            io_write(VEC[k][16] ? DAT : IDX, VEC[k][15:8]);
    end

    // R8: neighbouring addresses
    io_write(IDX, 8'hE7);
    io_write(16'h03F2, 8'h44);
    io_read(IDX, 8'hE7, "R8 index unchanged");
    io_read(DAT, 8'hFE, "R8 reg unchanged");
    io_read(16'h03F2, 8'hFF, "R8 read other");
    io_write(16'h03EF, 8'h10);
    io_read(IDX, 8'hE7, "R8 index unchanged low");

    // R7: closed window
    cfg_write(8'h85, 8'hFD);
    io_read(IDX, 8'hFF, "R7 closed idx");
    io_read(DAT, 8'hFF, "R7 closed data");
    io_write(IDX, 8'hE3);
    io_write(DAT, 8'h00);
    cfg_write(8'h85, 8'h02);
    io_read(IDX, 8'hE7, "R7 index held");
    io_read(DAT, 8'hFE, "R7 reg held");
    read_reg(8'hE3, 8'h11, "R7 E3 held");

    // R6: re-sampled on every write of the byte
    cfg_write(8'h85, 8'h00);
    io_read(IDX, 8'hFF, "R6 cleared");
    cfg_write(8'h85, 8'h06);
    io_read(IDX, 8'hE3, "R6 set again");

    // R5: reset restores defaults and index
    do_reset();
    cfg_write(8'h85, 8'h02);
    io_read(IDX, 8'h00, "R5 index after second reset");
    read_reg(8'hE2, 8'h03, "R5 E2 restored");
    read_reg(8'hF4, 8'h00, "R5 F4 cleared");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule